// File: doc/BRIEF.md
# Programmable DRAM Refresh Interval Timer

This block paces refresh for a DRAM controller. A 3-bit rate code selects how many host clocks pass between refresh requests, and a 2-bit clock-speed field says whether the host clock is the fast (100 MHz) or slow (66 MHz) setting. The timer counts down the interval and notes a pending refresh each time it expires. It raises `refresh_req` while at least one refresh is pending. Each `refresh_ack` pulse from the command logic retires one pending refresh.

Refresh starts only after `refresh_en` is set, so the timer stays silent while the memory is being brought up. A small combinational lookup turns a module's reported refresh-class byte into the rate code that start-up firmware would program. Issuing the refresh command itself, and any self-refresh or suspend behaviour, belong to other blocks.

The controller has three states. `ST_OFF` means no counting. `ST_LOAD` fills the down-counter with the interval for the current settings. `ST_RUN` counts down, and on expiry it reloads and logs a pending refresh. The transitions are:
- OFF to LOAD when the timer is enabled with valid settings.
- LOAD to RUN when the settings are stable.
- RUN or LOAD to LOAD when the rate or clock-speed field changes.
- Any state to OFF when the timer is disabled or a setting is invalid.

Top module: `refresh_timer`

## Requirements
- R1: After reset, `refresh_req` is 0 and `pending_cnt` is 0.
- R2: With `freq_sel`=00 and `rate_code` r in 1..5, requests are spaced BASE_FAST×2^(r-1) clocks apart. The default BASE_FAST of 1560 gives 15.6, 31.2, 62.4, 124.8 and 249.6 µs.
- R3: With `freq_sel`=10, the spacing is BASE_SLOW×2^(r-1) clocks. The default BASE_SLOW is 1030.
- R4: Rate codes 000 (off), 110 and 111 (reserved) produce no requests.
- R5: While `refresh_en` is 0, no request is added. After enabling with interval N, the first request is added at the (N+1)th rising edge after the edge that first samples the enable.
- R6: The reserved clock-speed codes 01 and 11 produce no requests.
- R7: A change of `rate_code` or `freq_sel` restarts the count. The first request under the new interval N is added N+1 edges after the edge that samples the change.
- R8: `refresh_req` stays high until acknowledged. Each `refresh_ack` cycle without an expiry lowers `pending_cnt` by one. An ack with nothing pending has no effect.
- R9: `pending_cnt` saturates at PEND_MAX (8). An expiry in the same cycle as an ack leaves the count unchanged.
- R10: `class_rate` maps bits 6:0 of `class_byte` as follows: 0→1, 1→5, 2→5, 3→2, 4→3, 5→4. Bit 7 is ignored, and indices of 6 or more give 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Allows refresh requests |
| rate_code | input | 3 | Interval selector |
| freq_sel | input | 2 | Host clock speed: 00 fast, 10 slow |
| refresh_ack | input | 1 | Retires one pending refresh |
| class_byte | input | 8 | Module's reported refresh class |
| class_rate | output | 3 | Rate code that class maps to |
| refresh_req | output | 1 | High while refreshes are pending |
| pending_cnt | output | PEND_W (4) | Number of outstanding refreshes |

## Verification
Each of the five valid rate codes is tried at both clock speeds. The first-request delay and the steady period are measured separately, so a wrong shift amount, a wrong base count and an off-by-one reload each show up in a different figure. The following cases are run with the timer otherwise enabled, to show that each one alone blocks requests:
- disabled rate codes
- reserved clock codes
- enable held low

Mid-count changes of the rate field and of the clock field separate a true reload from a timer that keeps its old count. The pending counter is driven into:
- a coinciding ack and expiry
- saturation
- acks with nothing pending

These cases tell apart count loss, overflow and underflow.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } ref_state_e;

    localparam int          RATE_W    = 3;
    localparam int          FREQ_W    = 2;
    localparam int          NUM_RATES = 5;
    localparam logic [1:0]  FREQ_FAST = 2'b00;
    localparam logic [1:0]  FREQ_SLOW = 2'b10;

endpackage

// File: rtl/refresh_class_map.sv
module refresh_class_map
    import refresh_timer_pkg::*;
(
    input  logic [7:0]        class_byte,
    output logic [RATE_W-1:0] class_rate
);
    logic [6:0] idx;

    assign idx = class_byte[6:0];

    always_comb begin
        case (idx)
            7'd0:    class_rate = 3'd1;
            7'd1:    class_rate = 3'd5;
            7'd2:    class_rate = 3'd5;
            7'd3:    class_rate = 3'd2;
            7'd4:    class_rate = 3'd3;
            7'd5:    class_rate = 3'd4;
            default: class_rate = 3'd0;
        endcase
    end

    // R10: the lookup never yields a reserved code
    always_comb begin
        a_r10_code_range: assert (class_rate <= 3'd5);
    end
endmodule

// File: rtl/refresh_interval_calc.sv
module refresh_interval_calc
    import refresh_timer_pkg::*;
#(
    parameter int BASE_FAST = 1560,
    parameter int BASE_SLOW = 1030,
    parameter int CNT_W     = 15
) (
    input  logic [RATE_W-1:0] rate_code,
    input  logic [FREQ_W-1:0] freq_sel,
    output logic [CNT_W-1:0]  interval,
    output logic              cfg_ok
);
    logic [CNT_W-1:0] fast_tab [NUM_RATES];
    logic [CNT_W-1:0] slow_tab [NUM_RATES];
    logic             rate_ok;
    logic             freq_ok;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_tab
        assign fast_tab[g] = CNT_W'(BASE_FAST << g);
        assign slow_tab[g] = CNT_W'(BASE_SLOW << g);
    end

    assign rate_ok = (rate_code >= 3'd1) && (rate_code <= 3'(NUM_RATES));
    assign freq_ok = (freq_sel == FREQ_FAST) || (freq_sel == FREQ_SLOW);
    assign cfg_ok  = rate_ok && freq_ok;

    always_comb begin
        interval = '0;
        if (cfg_ok) begin
            if (freq_sel == FREQ_FAST)
                interval = fast_tab[rate_code - 3'd1];
            else
                interval = slow_tab[rate_code - 3'd1];
        end
    end

    // R2/R3: a valid setting never gives an empty interval
    always_comb begin
        a_r2_interval_nonzero: assert (!cfg_ok || interval != '0);
    end
endmodule

// File: rtl/refresh_pend_ctr.sv
module refresh_pend_ctr #(
    parameter int PEND_MAX = 8,
    parameter int PEND_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              ack,
    output logic [PEND_W-1:0] count,
    output logic              req
);
    logic dec;
    logic at_max;

    assign at_max = (count == PEND_W'(PEND_MAX));
    assign dec    = ack && (count != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && !at_max) begin
            count <= count + 1'b1;
        end else if (dec && !inc) begin
            count <= count - 1'b1;
        end
    end

    assign req = (count != '0);

    // R9: never above the ceiling
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PEND_W'(PEND_MAX));

    // R8: without an ack the outstanding count never shrinks
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (count >= $past(count)));

    // R8: a lone ack retires exactly one
    a_r8_ack_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !inc && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
    import refresh_timer_pkg::*;
#(
    parameter  int BASE_FAST = 1560,
    parameter  int BASE_SLOW = 1030,
    parameter  int PEND_MAX  = 8,
    localparam int PEND_W    = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_en,
    input  logic [2:0]        rate_code,
    input  logic [1:0]        freq_sel,
    input  logic              refresh_ack,
    input  logic [7:0]        class_byte,
    output logic [2:0]        class_rate,
    output logic              refresh_req,
    output logic [PEND_W-1:0] pending_cnt
);
    localparam int BASE_MAX = (BASE_FAST > BASE_SLOW) ? BASE_FAST : BASE_SLOW;
    localparam int CNT_W    = $clog2((BASE_MAX << (NUM_RATES - 1)) + 1);

    ref_state_e                state_q, state_d;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          interval;
    logic                      cfg_ok;
    logic [RATE_W+FREQ_W-1:0]  cfg_q;
    logic                      cfg_chg;
    logic                      run_ok;
    logic                      expire;

    refresh_class_map u_map (
        .class_byte (class_byte),
        .class_rate (class_rate)
    );

    refresh_interval_calc #(
        .BASE_FAST (BASE_FAST),
        .BASE_SLOW (BASE_SLOW),
        .CNT_W     (CNT_W)
    ) u_calc (
        .rate_code (rate_code),
        .freq_sel  (freq_sel),
        .interval  (interval),
        .cfg_ok    (cfg_ok)
    );

    assign cfg_chg = ({rate_code, freq_sel} != cfg_q);
    assign run_ok  = refresh_en && cfg_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = run_ok ? ST_LOAD : ST_OFF;
            ST_LOAD: state_d = !run_ok ? ST_OFF : (cfg_chg ? ST_LOAD : ST_RUN);
            ST_RUN:  state_d = !run_ok ? ST_OFF : (cfg_chg ? ST_LOAD : ST_RUN);
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= {rate_code, freq_sel};
        end
    end

    assign expire = (state_q == ST_RUN) && run_ok && !cfg_chg && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: cnt_q <= interval;
                ST_RUN:  cnt_q <= expire ? interval : cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    refresh_pend_ctr #(
        .PEND_MAX (PEND_MAX),
        .PEND_W   (PEND_W)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (expire),
        .ack   (refresh_ack),
        .count (pending_cnt),
        .req   (refresh_req)
    );

    // R5: a cleared enable adds nothing on the next edge
    a_r5_disabled_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_en |=> (pending_cnt <= $past(pending_cnt)));

    // R4/R6: invalid settings add nothing
    a_r4_invalid_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> (pending_cnt <= $past(pending_cnt)));

    // R7: a settled load fills the counter with the selected interval
    a_r7_load_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && run_ok && !cfg_chg) |=> (cnt_q == $past(interval)));
endmodule

// File: tb/refresh_timer_tb_top.sv
module refresh_timer_tb_top;
    localparam int BF = 20;
    localparam int BS = 13;
    localparam int PM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_en = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic [1:0] freq_sel = 2'b00;
    logic       refresh_ack = 1'b0;
    logic [7:0] class_byte = 8'd0;
    logic [2:0] class_rate;
    logic       refresh_req;
    logic [3:0] pending_cnt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    refresh_timer #(.BASE_FAST(BF), .BASE_SLOW(BS), .PEND_MAX(PM)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_en  (refresh_en),
        .rate_code   (rate_code),
        .freq_sel    (freq_sel),
        .refresh_ack (refresh_ack),
        .class_byte  (class_byte),
        .class_rate  (class_rate),
        .refresh_req (refresh_req),
        .pending_cnt (pending_cnt)
    );

    // {freq, rate, expected period}
    localparam logic [20:0] VEC [10] = '{
        {2'b00, 3'd1, 16'(BF)},     {2'b00, 3'd2, 16'(BF * 2)},
        {2'b00, 3'd3, 16'(BF * 4)}, {2'b00, 3'd4, 16'(BF * 8)},
        {2'b00, 3'd5, 16'(BF * 16)},
        {2'b10, 3'd1, 16'(BS)},     {2'b10, 3'd2, 16'(BS * 2)},
        {2'b10, 3'd3, 16'(BS * 4)}, {2'b10, 3'd4, 16'(BS * 8)},
        {2'b10, 3'd5, 16'(BS * 16)}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // count rising edges until a request is seen at a falling edge
    task automatic wait_req(output int k);
        k = 0;
        do begin
            @(posedge clk);
            k++;
            @(negedge clk);
            refresh_ack = 1'b0;
        end while (!refresh_req && k < 2000);
    endtask

    task automatic drain();
        refresh_en = 1'b0;
        @(negedge clk);
        for (int g = 0; g < 20 && pending_cnt != 0; g++) begin
            refresh_ack = 1'b1;
            @(negedge clk);
            refresh_ack = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int k;
        logic [7:0] cb [6] = '{8'd0, 8'd3, 8'h83, 8'd5, 8'd6, 8'h7F};
        int         cr [6] = '{1, 2, 2, 4, 0, 0};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req", int'(refresh_req), 0);
        chk("R1 pending", int'(pending_cnt), 0);

        // R10 lookup
        for (int i = 0; i < 6; i++) begin
            class_byte = cb[i];
            #1;
            chk("R10 class", int'(class_rate), cr[i]);
        end
        class_byte = 8'd1; #1; chk("R10 class 1", int'(class_rate), 5);
        class_byte = 8'd2; #1; chk("R10 class 2", int'(class_rate), 5);
        class_byte = 8'd4; #1; chk("R10 class 4", int'(class_rate), 3);

        // R2 / R3 table walk: first delay N+2 counted edges, then period N
        for (int v = 0; v < 10; v++) begin
            drain();
            freq_sel   = VEC[v][20:19];
            rate_code  = VEC[v][18:16];
            refresh_en = 1'b1;
            wait_req(k);
            chk(VEC[v][20] ? "R3 first" : "R2 first", k, int'(VEC[v][15:0]) + 2);
            refresh_ack = 1'b1;
            wait_req(k);
            chk(VEC[v][20] ? "R3 period" : "R2 period", k, int'(VEC[v][15:0]));
        end

        // R4 disabled / reserved rate codes
        drain();
        freq_sel = 2'b00;
        refresh_en = 1'b1;
        rate_code = 3'd0; repeat (400) @(negedge clk);
        chk("R4 rate 000", int'(pending_cnt), 0);
        rate_code = 3'd6; repeat (400) @(negedge clk);
        chk("R4 rate 110", int'(pending_cnt), 0);
        rate_code = 3'd7; repeat (400) @(negedge clk);
        chk("R4 rate 111", int'(pending_cnt), 0);

        // R6 reserved clock codes
        rate_code = 3'd1;
        freq_sel = 2'b01; repeat (100) @(negedge clk);
        chk("R6 freq 01", int'(pending_cnt), 0);
        freq_sel = 2'b11; repeat (100) @(negedge clk);
        chk("R6 freq 11", int'(pending_cnt), 0);

        // R5 enable gate and restart
        refresh_en = 1'b0;
        freq_sel = 2'b00;
        repeat (200) @(negedge clk);
        chk("R5 disabled", int'(pending_cnt), 0);
        refresh_en = 1'b1;
        wait_req(k);
        chk("R5 restart", k, BF + 2);

        // R7 rate change mid-count
        drain();
        rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
        repeat (10) @(negedge clk);
        rate_code = 3'd2;
        wait_req(k);
        chk("R7 rate reload", k, 2 * BF + 2);

        // R7 clock change mid-count
        drain();
        rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
        repeat (5) @(negedge clk);
        freq_sel = 2'b10;
        wait_req(k);
        chk("R7 freq reload", k, BS + 2);

        // R8 / R9 hold, coinciding ack, saturation
        drain();
        rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
        wait_req(k);
        repeat (BF - 1) @(negedge clk);
        chk("R8 held", int'(refresh_req), 1);
        refresh_ack = 1'b1;
        @(negedge clk);
        refresh_ack = 1'b0;
        chk("R9 ack with expiry", int'(pending_cnt), 1);
        repeat (12 * BF) @(negedge clk);
        chk("R9 saturate", int'(pending_cnt), PM);
        refresh_en = 1'b0;
        @(negedge clk);
        refresh_ack = 1'b1;
        @(negedge clk);
        refresh_ack = 1'b0;
        chk("R8 single ack", int'(pending_cnt), PM - 1);
        drain();
        refresh_ack = 1'b1;
        @(negedge clk);
        refresh_ack = 1'b0;
        chk("R8 ack when empty", int'(pending_cnt), 0);
        chk("R8 req low", int'(refresh_req), 0);

        summary();
    end
endmodule